// File: doc/BRIEF.md
# Timer-Stamped Edge Capture Unit

This block time-stamps signal transitions on four independent input pins. Each pin passes through a synchronizer, and an edge detector fires on the edge chosen for that channel. When it fires, the current count of one of two free-running 16-bit timers is pushed into a two-deep stack that belongs to that channel. Channels 0 and 1 share one timer selector, and channels 2 and 3 share a second one.

Software reaches the unit through a small register port with a 3-bit address, a write strobe and a read strobe. Through this port it sets edge modes, timer choices and interrupt enables. It reads the occupancy of each stack from the upper byte of a status register and empties stacks by writing the lower byte. It pops captured values through one top-of-stack register per channel. Each capture also sets a per-channel flag. That flag drives an interrupt request when its enable is set, and software clears it by writing a 1 to it.

Top module: `cap_unit_top`

## Requirements
- R1: After reset the control register (address 0), the status register (address 1), the flag register (address 2), every top-of-stack register and irq_o all read zero.
- R2: Control bits [2k+1:2k] set the trigger edge of channel k: 00 disables capture, 01 selects rising edges, 10 selects falling edges and 11 selects both. An edge that does not match pushes nothing and sets no flag.
- R3: Control bit 8 selects the time base of channels 0 and 1, and bit 9 selects it for channels 2 and 3. A value of 0 selects timer_a_i and 1 selects timer_b_i. The captured word is that timer's value.
- R4: Each stack returns values oldest first. Its 2-bit status is 00 when empty, 01 with one entry and 10 with two entries. A read of top-of-stack register 4+k pops channel k.
- R5: A third capture with no pop in between sets the status to 11 and drops the oldest entry. The next pop returns the older of the two kept values and sets the status to 01.
- R6: Reading an empty stack returns the last value popped from it and leaves its status at 00.
- R7: Status bits [8+2k+1:8+2k] show the state of channel k, and bits [7:0] read as zero. Writing 1 to status bit k (k=0..3) empties channel k.
- R8: Flag bit k at address 2 is set on the clock edge that stores a capture of channel k. Writing 1 to that bit clears it, and writing 0 leaves it unchanged. A capture in the same cycle as a clear wins.
- R9: irq_o[k] is high exactly when flag k is set and control bit 12+k is set. Control bits 11:10 read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cap_i | input | 4 | Asynchronous capture pins, bit k for channel k |
| timer_a_i | input | 16 | Count of the first timer |
| timer_b_i | input | 16 | Count of the second timer |
| addr_i | input | 3 | Register address |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe; pops when the address is 4..7 |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i, combinational |
| irq_o | output | 4 | Interrupt request per channel |

## Verification
The bench toggles each pin both ways under every edge mode. A channel set to one edge must ignore the opposite edge, a channel set to both edges must take both, and a disabled channel must stay quiet. The two timers carry different values that change between captures, and the bench flips one pair selector. This shows that each selector steers only its own pair and that the stored word comes from the right timer. Runs of one, two and three captures before the pops, plus a read of an empty stack, separate correct ordering and dropping of the oldest entry from ordering that is reversed or keeps stale data. Writes of 0 and of 1 to the flag, status and enable bits show which bits act and which are ignored.

// File: rtl/cap_pkg.sv
package cap_pkg;
  localparam int unsigned CH_N   = 4;
  localparam int unsigned TS_W   = 16;
  localparam int unsigned REG_W  = 16;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned SYNC_N = 2;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_FLAG = 3'd2;
  localparam int unsigned       ADDR_TOP0 = 4;

  localparam int unsigned TSEL_LSB = 2 * CH_N;
  localparam int unsigned IEN_LSB  = 12;
  localparam int unsigned STAT_LSB = 8;
  localparam logic [REG_W-1:0] CTRL_WMASK = 16'hF3FF;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_sel_e;

  typedef enum logic [1:0] {
    ST_EMPTY = 2'b00,
    ST_ONE   = 2'b01,
    ST_TWO   = 2'b10,
    ST_OVF   = 2'b11
  } stk_st_e;
endpackage

// File: rtl/cap_edge_det.sv
module cap_edge_det
  import cap_pkg::*;
#(
  parameter int unsigned SYNC_LEN = SYNC_N
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      pin_i,
  input  edge_sel_e mode_i,
  output logic      hit_o
);
  // sh[SYNC_LEN-1] is the synchronized level, sh[SYNC_LEN] the previous one
  logic [SYNC_LEN:0] sh_q;
  logic cur, prv;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[SYNC_LEN-1:0], pin_i};
  end

  assign cur = sh_q[SYNC_LEN-1];
  assign prv = sh_q[SYNC_LEN];

  always_comb begin
    unique case (mode_i)
      EDGE_RISE: hit_o = cur & ~prv;
      EDGE_FALL: hit_o = ~cur & prv;
      EDGE_BOTH: hit_o = cur ^ prv;
      default:   hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/cap_stack.sv
module cap_stack
  import cap_pkg::*;
#(
  parameter int unsigned W = TS_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] push_val_i,
  input  logic         pop_i,
  input  logic         flush_i,
  output logic [W-1:0] top_o,
  output stk_st_e      st_o
);
  logic [W-1:0] top_q, bot_q, top_d, bot_d;
  stk_st_e st_q, st_d;

  always_comb begin
    top_d = top_q;
    bot_d = bot_q;
    st_d  = st_q;
    if (flush_i) begin
      st_d = ST_EMPTY;
    end else begin
      // pop before push so a same-cycle pair behaves as read then capture
      if (pop_i) begin
        unique case (st_q)
          ST_ONE:         st_d = ST_EMPTY;
          ST_TWO, ST_OVF: begin top_d = bot_q; st_d = ST_ONE; end
          default:        ;
        endcase
      end
      if (push_i) begin
        unique case (st_d)
          ST_EMPTY: begin top_d = push_val_i; st_d = ST_ONE; end
          ST_ONE:   begin bot_d = push_val_i; st_d = ST_TWO; end
          default:  begin top_d = bot_d; bot_d = push_val_i; st_d = ST_OVF; end
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      top_q <= '0;
      bot_q <= '0;
      st_q  <= ST_EMPTY;
    end else begin
      top_q <= top_d;
      bot_q <= bot_d;
      st_q  <= st_d;
    end
  end

  assign top_o = top_q;
  assign st_o  = st_q;

  a_r6_empty_pop_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && !flush_i && st_q == ST_EMPTY) |=> (st_q == ST_EMPTY && $stable(top_o)));

  a_r5_third_push_ovf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i && !flush_i && (st_q == ST_TWO || st_q == ST_OVF)) |=> (st_q == ST_OVF));

  a_r4_second_push_keeps_top: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i && !flush_i && st_q == ST_ONE) |=> (st_q == ST_TWO && $stable(top_o)));

  a_r7_flush_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (st_q == ST_EMPTY));
endmodule

// File: rtl/cap_unit_top.sv
module cap_unit_top
  import cap_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CH_N-1:0]   cap_i,
  input  logic [TS_W-1:0]   timer_a_i,
  input  logic [TS_W-1:0]   timer_b_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic [CH_N-1:0]   irq_o
);
  localparam int unsigned ST_W = 2 * CH_N;

  logic [REG_W-1:0] ctrl_q;
  logic [CH_N-1:0]  flags_q, cap_hit, flag_clr;
  logic [ST_W-1:0]  stat_bits;
  logic [TS_W-1:0]  top_w [CH_N];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              ctrl_q <= '0;
    else if (wr_en_i && addr_i == ADDR_CTRL)  ctrl_q <= wdata_i & CTRL_WMASK;
  end

  assign flag_clr = (wr_en_i && addr_i == ADDR_FLAG) ? wdata_i[CH_N-1:0] : '0;

  for (genvar i = 0; i < CH_N; i++) begin : g_ch
    localparam logic [ADDR_W-1:0] TOP_ADDR = ADDR_W'(ADDR_TOP0 + i);
    edge_sel_e       mode;
    logic [TS_W-1:0] stamp;
    logic            pop, flush;
    stk_st_e         st;

    assign mode  = edge_sel_e'(ctrl_q[2*i +: 2]);
    assign stamp = ctrl_q[TSEL_LSB + i/2] ? timer_b_i : timer_a_i;
    assign pop   = rd_en_i && addr_i == TOP_ADDR;
    assign flush = wr_en_i && addr_i == ADDR_STAT && wdata_i[i];

    cap_edge_det u_det (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pin_i  (cap_i[i]),
      .mode_i (mode),
      .hit_o  (cap_hit[i])
    );

    cap_stack #(.W(TS_W)) u_stk (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .push_i     (cap_hit[i]),
      .push_val_i (stamp),
      .pop_i      (pop),
      .flush_i    (flush),
      .top_o      (top_w[i]),
      .st_o       (st)
    );

    assign stat_bits[2*i +: 2] = st;
    assign irq_o[i] = flags_q[i] & ctrl_q[IEN_LSB + i];

    a_r8_flag_on_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cap_hit[i] |=> flags_q[i]);

    a_r9_irq_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ctrl_q[IEN_LSB + i] |-> !irq_o[i]);

    a_r2_off_no_flag_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode == EDGE_OFF && !flags_q[i]) |=> !flags_q[i]);
  end

  // set wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= (flags_q & ~flag_clr) | cap_hit;
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i[ADDR_W-1]) begin
      rdata_o = top_w[addr_i[1:0]];
    end else begin
      unique case (addr_i)
        ADDR_CTRL: rdata_o = ctrl_q;
        ADDR_STAT: rdata_o = {stat_bits, {STAT_LSB{1'b0}}};
        ADDR_FLAG: rdata_o = {{(REG_W-CH_N){1'b0}}, flags_q};
        default:   rdata_o = '0;
      endcase
    end
  end
endmodule

// File: tb/sim_cap_unit_top.sv
module sim_cap_unit_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  cap = '0;
  logic [15:0] tim_a = '0, tim_b = '0;
  logic [2:0]  addr = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [3:0]  irq;

  int n_chk = 0, n_fail = 0;
  logic [15:0] ctrl_m = '0;
  logic [3:0]  flag_m = '0;
  logic [15:0] sb [4][$];
  logic        ovf_m [4];
  logic [15:0] last_m [4];

  always #5 clk = ~clk;

  cap_unit_top u0 (
    .clk_i(clk), .rst_ni(rst_ni), .cap_i(cap), .timer_a_i(tim_a), .timer_b_i(tim_b),
    .addr_i(addr), .wr_en_i(wr_en), .rd_en_i(rd_en), .wdata_i(wdata),
    .rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(string req, logic [15:0] got, logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk); #1 wr_en = 1'b0;
    if (a == 3'd0) ctrl_m = d & 16'hF3FF;
    if (a == 3'd2) flag_m = flag_m & ~d[3:0];
    if (a == 3'd1) for (int k = 0; k < 4; k++) if (d[k]) begin sb[k].delete(); ovf_m[k] = 1'b0; end
  endtask

  task automatic rd(logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #2 d = rdata;
    @(posedge clk); #1 rd_en = 1'b0;
  endtask

  function automatic logic [15:0] exp_stat();
    logic [15:0] s = '0;
    for (int k = 0; k < 4; k++)
      s[8+2*k +: 2] = ovf_m[k] ? 2'b11 : 2'(sb[k].size());
    return s;
  endfunction

  // driver: toggles a pin and pushes the expected stamp into the scoreboard
  task automatic drive_pin(int ch, logic lvl);
    logic old = cap[ch];
    logic [1:0] m = ctrl_m[2*ch +: 2];
    logic hit = (m == 2'b01 && !old && lvl) || (m == 2'b10 && old && !lvl) ||
                (m == 2'b11 && old != lvl);
    logic [15:0] v = ctrl_m[8 + ch/2] ? tim_b : tim_a;
    @(negedge clk);
    cap[ch] = lvl;
    repeat (4) @(posedge clk);
    if (hit) begin
      if (sb[ch].size() == 2) begin void'(sb[ch].pop_front()); ovf_m[ch] = 1'b1; end
      sb[ch].push_back(v);
      flag_m[ch] = 1'b1;
    end
  endtask

  // monitor: pops a top-of-stack read and compares with the scoreboard
  task automatic mon_top(int ch, string req);
    logic [15:0] d, e;
    rd(3'(4 + ch), d);
    if (sb[ch].size() > 0) begin e = sb[ch].pop_front(); ovf_m[ch] = 1'b0; last_m[ch] = e; end
    else e = last_m[ch];
    check(req, d, e);
  endtask

  task automatic chk_stat(string req);
    logic [15:0] d;
    rd(3'd1, d);
    check(req, d, exp_stat());
  endtask

  task automatic chk_flag(string req);
    logic [15:0] d;
    rd(3'd2, d);
    check(req, d, {12'h0, flag_m});
  endtask

  task automatic chk_irq(string req);
    @(negedge clk); #1;
    check(req, {12'h0, irq}, {12'h0, flag_m & ctrl_m[15:12]});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog got=running exp=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [15:0] d;
    for (int k = 0; k < 4; k++) begin ovf_m[k] = 1'b0; last_m[k] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_ni = 1'b1;

    // R1 reset state
    rd(3'd0, d); check("R1 ctrl", d, 16'h0);
    chk_stat("R1 stat");
    chk_flag("R1 flag");
    chk_irq("R1 irq");
    rd(3'd7, d); check("R1 top3", d, 16'h0);

    // R2 modes: ch0 rise, ch1 fall, ch2 both, ch3 off; pair B on timer_b; R9 reserved bits drop
    wr(3'd0, 16'h0E39);
    rd(3'd0, d); check("R9 ctrl readback", d, 16'h0239);
    tim_a = 16'h1111; tim_b = 16'h2222;
    drive_pin(0, 1'b1);
    drive_pin(0, 1'b0);
    chk_stat("R2 rise only");
    mon_top(0, "R3 ch0 timer_a");
    tim_a = 16'h3333;
    drive_pin(1, 1'b1);
    drive_pin(1, 1'b0);
    tim_b = 16'h4444; drive_pin(2, 1'b1);
    tim_b = 16'h5555; drive_pin(2, 1'b0);
    chk_stat("R4 two entries");
    mon_top(2, "R4 oldest first");
    mon_top(2, "R4 second");
    mon_top(1, "R2 falling on ch1");
    drive_pin(3, 1'b1);
    drive_pin(3, 1'b0);
    chk_stat("R2 off channel quiet");
    chk_flag("R8 flags set");
    wr(3'd2, 16'h0000); chk_flag("R8 write 0 ignored");
    wr(3'd2, 16'h0001); chk_flag("R8 write 1 clears");

    // R3 flip pair A selector
    wr(3'd0, 16'h0339);
    tim_a = 16'h0AAA; tim_b = 16'h0BBB;
    drive_pin(0, 1'b1); drive_pin(0, 1'b0);
    mon_top(0, "R3 ch0 timer_b");
    wr(3'd0, 16'h0239);

    // R5 overflow
    tim_a = 16'hA001; drive_pin(0, 1'b1); drive_pin(0, 1'b0);
    tim_a = 16'hA002; drive_pin(0, 1'b1); drive_pin(0, 1'b0);
    tim_a = 16'hA003; drive_pin(0, 1'b1); drive_pin(0, 1'b0);
    chk_stat("R5 overflow status");
    mon_top(0, "R5 oldest dropped");
    chk_stat("R5 one left");
    mon_top(0, "R5 newest");
    // R6 empty read
    mon_top(0, "R6 empty read value");
    chk_stat("R6 status stays empty");

    // R7 flush
    tim_a = 16'hB001; drive_pin(0, 1'b1); drive_pin(0, 1'b0);
    tim_a = 16'hB002; drive_pin(0, 1'b1); drive_pin(0, 1'b0);
    wr(3'd1, 16'h0001);
    chk_stat("R7 flush and low byte zero");
    tim_a = 16'hC001; drive_pin(0, 1'b1); drive_pin(0, 1'b0);
    mon_top(0, "R7 after flush");

    // R9 interrupt masking
    chk_irq("R9 all masked");
    wr(3'd0, 16'h1239); chk_irq("R9 ch0 enabled");
    wr(3'd2, 16'h0001); chk_irq("R9 cleared flag");
    wr(3'd0, 16'h3239); chk_irq("R9 ch1 enabled");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule